// File: doc/BRIEF.md
# Saturating Delta Sample Output Unit

This block turns a stream of 1-bit delta-coded sample bytes into a 7-bit DAC code. A fetch engine hands it whole bytes with a one-cycle valid strobe. The block serializes each byte, least-significant bit first, and uses each bit to step a 6-bit counter up or down by one. The counter clips at its two end values and never wraps. A bit-rate tick input sets the pace. The fetch engine pulses this tick eight times per byte period.

The counter forms the upper six bits of the output code. The lowest bit comes from a separate latch. The CPU can write both at once through a direct-load port, which lets software drive the output directly as raw PCM. A one-byte holding buffer sits between the fetch engine and the shifter, so a new byte can arrive while the previous one is still being played.

Top module: `delta_sample_out`

## Requirements
- R1: While reset is asserted, and after it is released with no further stimulus, `code_o` is 0.
- R2: The bits of a byte are consumed in the order bit 0, bit 1, and so on up to bit 7.
- R3: Each cycle with `tick_i` high consumes exactly one bit while the shifter holds data. In a cycle without a tick or a load, `code_o` is unchanged in the next cycle.
- R4: A consumed bit of 1 raises `code_o[6:1]` by one, and a consumed bit of 0 lowers it by one.
- R5: `code_o[6:1]` saturates. A 1 bit at 63 leaves it at 63, and a 0 bit at 0 leaves it at 0.
- R6: When `ld_we_i` is high, `code_o` equals `ld_data_i[6:0]` in the next cycle, and `ld_data_i[7]` is ignored.
- R7: `code_o[0]` changes only through a direct load. Delta steps never touch it.
- R8: A direct load in the same cycle as a tick wins over the delta step. The bit that tick consumes is discarded.
- R9: A byte presented while the shifter is busy is held. It enters the shifter in the first cycle in which the shifter is empty, and is then played in full after the earlier byte. A tick in that transfer cycle finds no data.
- R10: A tick that arrives while the shifter is empty leaves `code_o` unchanged.
- R11: A byte presented while the holding buffer is already full replaces the held byte. Only the newer byte is played.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Bit-rate strobe, eight per byte period |
| smp_valid_i | input | 1 | New sample byte strobe from the fetch engine |
| smp_byte_i | input | 8 | Sample byte, bit 0 played first |
| ld_we_i | input | 1 | CPU direct-load write strobe |
| ld_data_i | input | 8 | Direct-load value; [6:1] goes to the counter, [0] to the output LSB, [7] is unused |
| code_o | output | 7 | DAC code: counter in [6:1], load-written LSB in [0] |

## Verification
The assertions check several rules on every cycle. The counter moves by at most one step without a load. The LSB holds between loads. A load shows up exactly one cycle later. The output holds when there is no tick. An up step at 63 or a down step at 0 is held off.

The bit order, the holding buffer, the replacement of a held byte, and the lost tick in the transfer cycle are all properties of whole byte sequences. Only the bench's directed scenarios show them: bytes of known pattern are compared with hand-computed codes. A long random run is then checked against a cycle model written from the requirements.

// File: rtl/dso_pkg.sv
package dso_pkg;

  // Operation the shifter asks of the delta counter in one cycle
  typedef enum logic [1:0] {
    DLT_HOLD = 2'd0,
    DLT_UP   = 2'd1,
    DLT_DOWN = 2'd2
  } dlt_op_e;

endpackage

// File: rtl/dso_feed.sv
// One-byte holding buffer between the fetch engine and the shifter.
module dso_feed #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_byte_i,
  input  logic              take_i,
  output logic              held_o,
  output logic [BYTE_W-1:0] held_byte_o
);

  logic              full_q, full_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              byte_en;

  // A new byte always lands here; it overwrites a held byte if one is waiting
  always_comb begin
    full_d  = full_q;
    byte_d  = byte_q;
    byte_en = 1'b0;
    if (in_valid_i) begin
      full_d  = 1'b1;
      byte_d  = in_byte_i;
      byte_en = 1'b1;
    end else if (take_i) begin
      full_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (byte_en) begin
      byte_q <= byte_d;
    end
  end

  assign held_o      = full_q;
  assign held_byte_o = byte_q;

endmodule

// File: rtl/dso_shifter.sv
// Serializer: plays one bit per tick, LSB first, and requests counter steps.
module dso_shifter
  import dso_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              held_i,
  input  logic [BYTE_W-1:0] held_byte_i,
  output logic              take_o,
  output dlt_op_e           op_o
);

  localparam int unsigned LEFT_W = $clog2(BYTE_W + 1);
  localparam logic [LEFT_W-1:0] LEFT_FULL = LEFT_W'(BYTE_W);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              empty;
  logic              step;

  assign empty  = (left_q == '0);
  assign step   = tick_i && !empty;
  assign take_o = empty && held_i;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (take_o) begin
      sh_d   = held_byte_i;
      left_d = LEFT_FULL;
    end else if (step) begin
      sh_d   = {1'b0, sh_q[BYTE_W-1:1]};
      left_d = left_q - 1'b1;
    end
  end

  always_comb begin
    op_o = DLT_HOLD;
    if (step) begin
      op_o = sh_q[0] ? DLT_UP : DLT_DOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (take_o || step) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

endmodule

// File: rtl/dso_delta.sv
// Clipping up/down counter plus the separately loaded output LSB.
module dso_delta
  import dso_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned LD_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dlt_op_e          op_i,
  input  logic             ld_we_i,
  input  logic [LD_W-1:0]  ld_data_i,
  output logic [CNT_W:0]   code_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lsb_q, lsb_d;
  logic             cnt_en;

  generate
    if (LD_W > CNT_W + 1) begin : g_ld_spare
      logic unused_ld_hi;
      assign unused_ld_hi = ^ld_data_i[LD_W-1:CNT_W+1];
    end
  endgenerate

  // The direct load has priority over any delta step in the same cycle
  always_comb begin
    cnt_d  = cnt_q;
    lsb_d  = lsb_q;
    cnt_en = 1'b0;
    if (ld_we_i) begin
      cnt_d  = ld_data_i[CNT_W:1];
      lsb_d  = ld_data_i[0];
      cnt_en = 1'b1;
    end else begin
      unique case (op_i)
        DLT_UP: begin
          if (cnt_q != CNT_MAX) begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
        DLT_DOWN: begin
          if (cnt_q != CNT_MIN) begin
            cnt_d  = cnt_q - 1'b1;
            cnt_en = 1'b1;
          end
        end
        default: cnt_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q <= 1'b0;
    end else if (ld_we_i) begin
      lsb_q <= lsb_d;
    end
  end

  assign code_o = {cnt_q, lsb_q};

endmodule

// File: rtl/delta_sample_out.sv
module delta_sample_out
  import dso_pkg::*;
#(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              smp_valid_i,
  input  logic [BYTE_W-1:0] smp_byte_i,
  input  logic              ld_we_i,
  input  logic [LD_W-1:0]   ld_data_i,
  output logic [CNT_W:0]    code_o
);

  // Reset asserts asynchronously and releases on a clock edge
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              held_w;
  logic [BYTE_W-1:0] held_byte_w;
  logic              take_w;
  dlt_op_e           op_w;

  dso_feed #(.BYTE_W(BYTE_W)) i_feed (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .in_valid_i  (smp_valid_i),
    .in_byte_i   (smp_byte_i),
    .take_i      (take_w),
    .held_o      (held_w),
    .held_byte_o (held_byte_w)
  );

  dso_shifter #(.BYTE_W(BYTE_W)) i_shift (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick_i      (tick_i),
    .held_i      (held_w),
    .held_byte_i (held_byte_w),
    .take_o      (take_w),
    .op_o        (op_w)
  );

  dso_delta #(.CNT_W(CNT_W), .LD_W(LD_W)) i_delta (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op_i      (op_w),
    .ld_we_i   (ld_we_i),
    .ld_data_i (ld_data_i),
    .code_o    (code_o)
  );

endmodule

// File: rtl/dso_chk.sv
module dso_chk
  import dso_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned LD_W  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_i,
  input logic            ld_we_i,
  input logic [LD_W-1:0] ld_data_i,
  input dlt_op_e         op,
  input logic [CNT_W:0]  code_o
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R1 / R3: no tick and no load keeps the output still
  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ld_we_i) |=> $stable(code_o));

  // R4: without a load the counter moves by at most one step
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_we_i |=> ((code_o[CNT_W:1] == $past(code_o[CNT_W:1])) ||
                  ({1'b0, code_o[CNT_W:1]} == {1'b0, $past(code_o[CNT_W:1])} + 1'b1) ||
                  ({1'b0, code_o[CNT_W:1]} + 1'b1 == {1'b0, $past(code_o[CNT_W:1])})));

  // R4: an up request below the top raises the counter by one
  a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op == DLT_UP && !ld_we_i && code_o[CNT_W:1] != CMAX) |=>
      (code_o[CNT_W:1] == $past(code_o[CNT_W:1]) + 1'b1));

  // R5: clipping at both ends
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op == DLT_UP && !ld_we_i && code_o[CNT_W:1] == CMAX) |=> (code_o[CNT_W:1] == CMAX));

  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op == DLT_DOWN && !ld_we_i && code_o[CNT_W:1] == '0) |=> (code_o[CNT_W:1] == '0));

  // R6 / R8: a load always shows up one cycle later, whatever the tick did
  a_r6_load_seen: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we_i |=> (code_o == $past(ld_data_i[CNT_W:0])));

  // R7: the LSB only changes through a load
  a_r7_lsb_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_we_i |=> $stable(code_o[0]));

endmodule

bind delta_sample_out dso_chk #(.CNT_W(CNT_W), .LD_W(LD_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick_i    (tick_i),
  .ld_we_i   (ld_we_i),
  .ld_data_i (ld_data_i),
  .op        (op_w),
  .code_o    (code_o)
);

// File: tb/test_delta_sample_out.sv
`timescale 1ns/1ps
module test_delta_sample_out;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       smp_valid;
  logic [7:0] smp_byte;
  logic       ld_we;
  logic [7:0] ld_data;
  logic [6:0] code;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  delta_sample_out i_delta_sample_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .smp_valid_i (smp_valid),
    .smp_byte_i  (smp_byte),
    .ld_we_i     (ld_we),
    .ld_data_i   (ld_data),
    .code_o      (code)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // Reference state written from the requirements
  logic [5:0] m_cnt;
  logic       m_lsb;
  logic [7:0] m_sh;
  int         m_left;
  logic [7:0] m_buf;
  logic       m_full;

  function automatic logic [5:0] sat_step(input logic [5:0] c, input logic b);
    if (b)  return (c == 6'd63) ? c : c + 6'd1;
    else    return (c == 6'd0)  ? c : c - 6'd1;
  endfunction

  task automatic model_step(input bit t, input bit v, input logic [7:0] b,
                            input bit w, input logic [7:0] d);
    bit xfer;
    xfer = (m_left == 0) && m_full;
    if (t && m_left != 0) begin
      if (!w) m_cnt = sat_step(m_cnt, m_sh[0]);
      m_sh   = m_sh >> 1;
      m_left = m_left - 1;
    end
    if (w) begin
      m_cnt = d[6:1];
      m_lsb = d[0];
    end
    if (xfer) begin
      m_sh   = m_buf;
      m_left = 8;
    end
    if (v) begin
      m_buf  = b;
      m_full = 1'b1;
    end else if (xfer) begin
      m_full = 1'b0;
    end
  endtask

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: code actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // One clock: drive after the falling edge, sample at the next falling edge
  task automatic cyc(input bit t, input bit v, input logic [7:0] b,
                     input bit w, input logic [7:0] d);
    tick = t; smp_valid = v; smp_byte = b; ld_we = w; ld_data = d;
    @(posedge clk);
    model_step(t, v, b, w, d);
    @(negedge clk);
    tick = 1'b0; smp_valid = 1'b0; ld_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 8'h00);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 8'h00, 0, 8'h00);
  endtask

  task automatic load(input logic [7:0] d);
    cyc(0, 0, 8'h00, 1, d);
  endtask

  task automatic feed(input logic [7:0] b);
    cyc(0, 1, b, 0, 8'h00);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: cycles actual=%0d expected<=150000", cycles);
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd7;
    void'($urandom(seed));
    rst_n = 1'b0; tick = 0; smp_valid = 0; smp_byte = 0; ld_we = 0; ld_data = 0;
    m_cnt = 0; m_lsb = 0; m_sh = 0; m_left = 0; m_buf = 0; m_full = 0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", code, 7'h00);
    rst_n = 1'b1;
    idle(4);
    chk("R1 after release", code, 7'h00);

    // R6: bit 7 ignored
    load(8'hAB);
    chk("R6 load", code, 7'h2B);

    // R2 / R4: 0x0F plays 1,1,1,1 then 0,0,0,0
    load(8'h40);
    feed(8'h0F); idle(2);
    ticks(4);
    chk("R2 lsb first", code, 7'h48);
    ticks(4);
    chk("R4 down steps", code, 7'h40);
    // R10: shifter empty
    ticks(3);
    chk("R10 empty tick", code, 7'h40);
    // R3: no tick, no change
    idle(3);
    chk("R3 no tick hold", code, 7'h40);

    // R5: clip at top and bottom
    load(8'h7F); feed(8'hFF); idle(2); ticks(8);
    chk("R5 clip top", code, 7'h7F);
    load(8'h00); feed(8'h00); idle(2); ticks(8);
    chk("R5 clip bottom", code, 7'h00);

    // R7: LSB survives delta steps
    load(8'h01); feed(8'hFF); idle(2); ticks(8);
    chk("R7 lsb kept", code, 7'h11);

    // R8: load and tick in one cycle
    load(8'h40); feed(8'hFF); idle(2);
    cyc(1, 0, 8'h00, 1, 8'h20);
    chk("R8 load wins", code, 7'h20);
    ticks(1);
    chk("R8 next bit", code, 7'h22);
    ticks(6);
    chk("R8 rest of byte", code, 7'h2E);

    // R9: second byte held during the first
    load(8'h40); feed(8'hFF); idle(2);
    feed(8'h00); idle(1);
    ticks(8);
    chk("R9 first byte", code, 7'h50);
    idle(1);
    ticks(8);
    chk("R9 held byte", code, 7'h40);

    // R11: newer byte replaces held one
    load(8'h40); feed(8'h55); idle(2);
    feed(8'hFF); feed(8'h00); idle(1);
    ticks(8);
    chk("R11 first byte", code, 7'h40);
    idle(1);
    ticks(8);
    chk("R11 replaced", code, 7'h30);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      bit t, v, w;
      logic [7:0] b, d;
      t = ($urandom % 3) == 0;
      v = ($urandom % 12) == 0;
      w = ($urandom % 50) == 0;
      b = 8'($urandom);
      d = 8'($urandom);
      cyc(t, v, b, w, d);
      chk("R4 random vs model", code, {m_cnt, m_lsb});
    end

    finish_run();
  end

endmodule